// File: doc/BRIEF.md
# Driver Fault Supervisor and Gating

This block sits between the command register of a twelve-output half-bridge driver and the gate drivers themselves. It takes the enables that software has programmed, one per high-side and low-side switch, and turns them into the gate commands that actually reach the switches. On the way it applies every protection event: overcurrent and under-load faults on single outputs, over- and undervoltage on the supplies, and thermal warning and shutdown from one sensor per switch pair.

The three fault classes act differently. A filtered overcurrent or under-load event may latch its own output off until software issues a status clear. A supply fault and a thermal shutdown force every output off only while they persist, and they leave the programmed selection untouched, so outputs come back with no new command. Four sticky status flags and the gated output states are handed to the serial interface for read-back. A low level on the enable input puts the block in sleep, where nothing is kept.

Top module: `driver_fault_supervisor`

## Requirements
- R1: While rst_n or en_pin is low, all gate commands and all four flags are 0 on the following clock edge; no state survives sleep.
- R2: With no fault active, gate_on equals the prog_on value sampled at the previous clock edge; a gate bit is never 1 unless its prog_on bit was 1 on the edge before.
- R3: An overcurrent level on an output whose gate is on counts as an event only after OC_FILT consecutive sampled cycles (default 4); each event sets flag_overload, which stays set until a status clear. A shorter pulse sets nothing.
- R4: With oc_shut_en high, an overcurrent event turns that output off and holds it off until a status clear, other outputs unaffected; with oc_shut_en low the output stays as programmed.
- R5: An under-load level on an output whose gate is on must persist UL_FILT consecutive cycles (default 10) to set flag_underload; with ul_shut_en high that output is also latched off until a status clear.
- R6: Overvoltage sets flag_supply; with ov_lock_en high all gates are 0 while it lasts, and the programmed outputs return on the edge after it ends; with ov_lock_en low gates are unaffected.
- R7: Undervoltage sets flag_supply and holds all gates at 0 while it lasts, whatever ov_lock_en is.
- R8: Any thermal warning level sets flag_thermal while outputs stay on; the flag remains set after the warning ends until a status clear.
- R9: Any thermal shutdown level forces all gates to 0 on the next edge, no output can turn on while one is present, and the programmed outputs return on the edge after the last one ends.
- R10: A status_clr pulse clears all four flags and every per-output latch-off on the next edge; a condition still present sets its flag again one edge later.
- R11: A filter count restarts from zero whenever its level drops or its output gate is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Enable; low means sleep and clears all state |
| prog_on | input | NOUT | Programmed output enables, bit 2k low side k, bit 2k+1 high side k |
| oc_lvl | input | NOUT | Per-output overcurrent comparator level |
| ul_lvl | input | NOUT | Per-output under-load comparator level |
| ov_lvl | input | 1 | Overvoltage on either supply |
| uv_lvl | input | 1 | Undervoltage on either supply |
| tw_lvl | input | NOUT/2 | Thermal warning level per switch pair |
| tsd_lvl | input | NOUT/2 | Thermal shutdown level per switch pair |
| oc_shut_en | input | 1 | Overcurrent shutdown enable |
| ul_shut_en | input | 1 | Under-load shutdown enable |
| ov_lock_en | input | 1 | Overvoltage lockout enable |
| status_clr | input | 1 | One-cycle status and latch-off clear |
| gate_on | output | NOUT | Gated commands to the switches, also read back |
| flag_overload | output | 1 | Sticky overcurrent flag |
| flag_underload | output | 1 | Sticky under-load flag |
| flag_supply | output | 1 | Sticky supply fault flag |
| flag_thermal | output | 1 | Sticky thermal warning flag |

## Verification
Every cycle the assertions confirm that sleep, undervoltage, locked-out overvoltage and thermal shutdown leave all gates at 0, that no gate ever exceeds the previous programmed enables, that the thermal flag only falls through a clear, that a clear empties all flags, and that an overload flag only rises behind an overcurrent level. The exact filter lengths, the latch-off of only the offending output and its release, the re-setting of a flag whose cause outlives the clear, and the return of programmed outputs after supply and thermal faults are shown by the bench's scenarios.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
    typedef struct packed {
        logic overload;
        logic underload;
        logic supply;
        logic thermal;
    } dfs_flags_t;
endpackage

// File: rtl/dfs_persist.sv
module dfs_persist #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    input  logic cond,
    output logic fire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (sleep || !cond) begin
            cnt_d = '0;
        end else if (cnt_q == TOP) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
        fire = cond && !sleep && (cnt_q == TOP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dfs_global.sv
module dfs_global #(
    parameter int NSENS = 6
) (
    input  logic [NSENS-1:0] tsd_lvl,
    input  logic             ov_lvl,
    input  logic             uv_lvl,
    input  logic             ov_lock_en,
    output logic             all_off
);
    always_comb begin
        all_off = (|tsd_lvl) || uv_lvl || (ov_lvl && ov_lock_en);
    end
endmodule

// File: rtl/driver_fault_supervisor.sv
module driver_fault_supervisor #(
    parameter int NOUT    = 12,
    parameter int OC_FILT = 4,
    parameter int UL_FILT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_pin,
    input  logic [NOUT-1:0]   prog_on,
    input  logic [NOUT-1:0]   oc_lvl,
    input  logic [NOUT-1:0]   ul_lvl,
    input  logic              ov_lvl,
    input  logic              uv_lvl,
    input  logic [NOUT/2-1:0] tw_lvl,
    input  logic [NOUT/2-1:0] tsd_lvl,
    input  logic              oc_shut_en,
    input  logic              ul_shut_en,
    input  logic              ov_lock_en,
    input  logic              status_clr,
    output logic [NOUT-1:0]   gate_on,
    output logic              flag_overload,
    output logic              flag_underload,
    output logic              flag_supply,
    output logic              flag_thermal
);
    import dfs_pkg::*;

    localparam int NSENS = NOUT / 2;

    typedef struct packed {
        logic [NOUT-1:0] gate;
        logic [NOUT-1:0] latch_off;
        dfs_flags_t      flags;
    } dfs_state_t;

    dfs_state_t state_d, state_q;

    logic            sleep;
    logic            all_off;
    logic [NOUT-1:0] oc_fire;
    logic [NOUT-1:0] ul_fire;

    assign sleep = !en_pin;

    // per-output persistence filters, armed only while the gate is on
    for (genvar i = 0; i < NOUT; i++) begin : g_filt
        dfs_persist #(.LIMIT(OC_FILT)) u_oc (
            .clk   (clk),
            .rst_n (rst_n),
            .sleep (sleep),
            .cond  (oc_lvl[i] && state_q.gate[i]),
            .fire  (oc_fire[i])
        );
        dfs_persist #(.LIMIT(UL_FILT)) u_ul (
            .clk   (clk),
            .rst_n (rst_n),
            .sleep (sleep),
            .cond  (ul_lvl[i] && state_q.gate[i]),
            .fire  (ul_fire[i])
        );
    end

    dfs_global #(.NSENS(NSENS)) u_global (
        .tsd_lvl    (tsd_lvl),
        .ov_lvl     (ov_lvl),
        .uv_lvl     (uv_lvl),
        .ov_lock_en (ov_lock_en),
        .all_off    (all_off)
    );

    always_comb begin
        state_d = state_q;
        if (sleep) begin
            state_d = '0;
        end else if (status_clr) begin
            state_d.latch_off = '0;
            state_d.flags     = '0;
            state_d.gate      = all_off ? '0 : prog_on;
        end else begin
            state_d.latch_off = state_q.latch_off
                              | (oc_fire & {NOUT{oc_shut_en}})
                              | (ul_fire & {NOUT{ul_shut_en}});
            state_d.flags.overload  = state_q.flags.overload  || (|oc_fire);
            state_d.flags.underload = state_q.flags.underload || (|ul_fire);
            state_d.flags.supply    = state_q.flags.supply    || ov_lvl || uv_lvl;
            state_d.flags.thermal   = state_q.flags.thermal   || (|tw_lvl);
            state_d.gate = all_off ? '0 : (prog_on & ~state_d.latch_off);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign gate_on        = state_q.gate;
    assign flag_overload  = state_q.flags.overload;
    assign flag_underload = state_q.flags.underload;
    assign flag_supply    = state_q.flags.supply;
    assign flag_thermal   = state_q.flags.thermal;
endmodule

// File: rtl/dfs_checker.sv
module dfs_checker #(
    parameter int NOUT = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_pin,
    input logic [NOUT-1:0]   prog_on,
    input logic [NOUT-1:0]   oc_lvl,
    input logic              ov_lvl,
    input logic              uv_lvl,
    input logic [NOUT/2-1:0] tsd_lvl,
    input logic              ov_lock_en,
    input logic              status_clr,
    input logic [NOUT-1:0]   gate_on,
    input logic              flag_overload,
    input logic              flag_underload,
    input logic              flag_supply,
    input logic              flag_thermal
);
    assert_sleep_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_pin |=> (gate_on == '0 && !flag_overload && !flag_underload
                     && !flag_supply && !flag_thermal));

    assert_gate_within_prog_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((gate_on & ~$past(prog_on)) == '0));

    assert_overload_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_overload) |-> $past(|oc_lvl));

    assert_ov_lockout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_lvl && ov_lock_en) |=> gate_on == '0);

    assert_uv_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        uv_lvl |=> gate_on == '0);

    assert_thermal_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_thermal && en_pin && !status_clr) |=> flag_thermal);

    assert_tsd_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|tsd_lvl) |=> gate_on == '0);

    assert_clear_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        status_clr |=> (!flag_overload && !flag_underload && !flag_supply && !flag_thermal));
endmodule

bind driver_fault_supervisor dfs_checker #(.NOUT(NOUT)) u_dfs_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .en_pin         (en_pin),
    .prog_on        (prog_on),
    .oc_lvl         (oc_lvl),
    .ov_lvl         (ov_lvl),
    .uv_lvl         (uv_lvl),
    .tsd_lvl        (tsd_lvl),
    .ov_lock_en     (ov_lock_en),
    .status_clr     (status_clr),
    .gate_on        (gate_on),
    .flag_overload  (flag_overload),
    .flag_underload (flag_underload),
    .flag_supply    (flag_supply),
    .flag_thermal   (flag_thermal)
);

// File: tb/tb_driver_fault_supervisor.sv
module tb_driver_fault_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int NOUT = 12;
    localparam int NS   = NOUT / 2;
    localparam int OCF  = 4;
    localparam int ULF  = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            en_pin = 1'b1;
    logic [NOUT-1:0] prog_on = '0;
    logic [NOUT-1:0] oc_lvl = '0;
    logic [NOUT-1:0] ul_lvl = '0;
    logic            ov_lvl = 1'b0;
    logic            uv_lvl = 1'b0;
    logic [NS-1:0]   tw_lvl = '0;
    logic [NS-1:0]   tsd_lvl = '0;
    logic            oc_shut_en = 1'b0;
    logic            ul_shut_en = 1'b0;
    logic            ov_lock_en = 1'b0;
    logic            status_clr = 1'b0;
    logic [NOUT-1:0] gate_on;
    logic            flag_overload, flag_underload, flag_supply, flag_thermal;

    always #(CLK_PERIOD/2) clk = ~clk;

    driver_fault_supervisor #(.NOUT(NOUT), .OC_FILT(OCF), .UL_FILT(ULF)) dut (
        .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .prog_on(prog_on),
        .oc_lvl(oc_lvl), .ul_lvl(ul_lvl), .ov_lvl(ov_lvl), .uv_lvl(uv_lvl),
        .tw_lvl(tw_lvl), .tsd_lvl(tsd_lvl), .oc_shut_en(oc_shut_en),
        .ul_shut_en(ul_shut_en), .ov_lock_en(ov_lock_en), .status_clr(status_clr),
        .gate_on(gate_on), .flag_overload(flag_overload), .flag_underload(flag_underload),
        .flag_supply(flag_supply), .flag_thermal(flag_thermal)
    );

    // flag nibble order: overload, underload, supply, thermal
    typedef struct {
        string           req;
        logic [NOUT-1:0] gate;
        logic [3:0]      flags;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    localparam logic [3:0] F_NONE = 4'b0000;
    localparam logic [3:0] F_OL   = 4'b1000;
    localparam logic [3:0] F_UL   = 4'b0100;
    localparam logic [3:0] F_PSF  = 4'b0010;
    localparam logic [3:0] F_TW   = 4'b0001;

    // advance n edges, then settle just after the last one
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string req, input logic [NOUT-1:0] g, input logic [3:0] f);
        exp_t e;
        e.req = req; e.gate = g; e.flags = f;
        exp_q.push_back(e);
    endtask

    // monitor: compare at the falling edge after each expectation
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                logic [3:0] act_f;
                e = exp_q.pop_front();
                act_f = {flag_overload, flag_underload, flag_supply, flag_thermal};
                n_tests++;
                if (gate_on !== e.gate || act_f !== e.flags) begin
                    n_fail++;
                    $display("FAIL %s: gate=%h flags=%b expected gate=%h flags=%b",
                             e.req, gate_on, act_f, e.gate, e.flags);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        step(2);
        expect_out("R1 reset", '0, F_NONE);
        rst_n = 1'b1;

        prog_on = 12'h0A5; step(1);
        expect_out("R2 follow", 12'h0A5, F_NONE);

        // R3/R11 short overcurrent pulse
        oc_lvl[0] = 1'b1; step(OCF - 1);
        oc_lvl[0] = 1'b0; step(1);
        expect_out("R3 short pulse", 12'h0A5, F_NONE);

        // R3/R4 shutdown disabled
        oc_lvl[0] = 1'b1; step(OCF - 1);
        expect_out("R3 before filter", 12'h0A5, F_NONE);
        step(1);
        expect_out("R4 flag only", 12'h0A5, F_OL);

        // R10 clear while still present
        status_clr = 1'b1; step(1);
        expect_out("R10 cleared", 12'h0A5, F_NONE);
        status_clr = 1'b0; step(1);
        expect_out("R10 re-set", 12'h0A5, F_OL);

        // R4 shutdown enabled
        oc_shut_en = 1'b1; step(1);
        expect_out("R4 latch off", 12'h0A4, F_OL);
        oc_lvl[0] = 1'b0; step(2);
        expect_out("R4 held", 12'h0A4, F_OL);
        status_clr = 1'b1; step(1);
        expect_out("R10 release", 12'h0A5, F_NONE);
        status_clr = 1'b0;

        // R5 under-load with shutdown
        ul_shut_en = 1'b1; ul_lvl[2] = 1'b1; step(ULF - 1);
        expect_out("R5 before delay", 12'h0A5, F_NONE);
        step(1);
        expect_out("R5 latch off", 12'h0A1, F_UL);
        ul_lvl[2] = 1'b0; status_clr = 1'b1; step(1);
        expect_out("R10 ul release", 12'h0A5, F_NONE);
        status_clr = 1'b0;

        // R11 restart after a one-cycle drop
        ul_lvl[5] = 1'b1; step(5);
        ul_lvl[5] = 1'b0; step(1);
        ul_lvl[5] = 1'b1; step(ULF - 1);
        expect_out("R11 restart", 12'h0A5, F_NONE);
        step(1);
        expect_out("R11 full count", 12'h085, F_UL);
        ul_lvl[5] = 1'b0; status_clr = 1'b1; step(1);
        status_clr = 1'b0;
        expect_out("R10 clean", 12'h0A5, F_NONE);

        // R6 overvoltage
        ov_lvl = 1'b1; step(1);
        expect_out("R6 no lockout", 12'h0A5, F_PSF);
        ov_lock_en = 1'b1; step(1);
        expect_out("R6 lockout", 12'h000, F_PSF);
        ov_lvl = 1'b0; step(1);
        expect_out("R6 resume", 12'h0A5, F_PSF);
        status_clr = 1'b1; step(1);
        status_clr = 1'b0;

        // R7 undervoltage
        ov_lock_en = 1'b0; uv_lvl = 1'b1; step(1);
        expect_out("R7 uv off", 12'h000, F_PSF);
        uv_lvl = 1'b0; step(1);
        expect_out("R7 resume", 12'h0A5, F_PSF);
        status_clr = 1'b1; step(1);
        status_clr = 1'b0;

        // R8 thermal warning
        tw_lvl[3] = 1'b1; step(1);
        expect_out("R8 warn", 12'h0A5, F_TW);
        tw_lvl[3] = 1'b0; step(2);
        expect_out("R8 sticky", 12'h0A5, F_TW);
        status_clr = 1'b1; step(1);
        expect_out("R8 cleared", 12'h0A5, F_NONE);
        status_clr = 1'b0;

        // R9 thermal shutdown
        tsd_lvl[4] = 1'b1; step(1);
        expect_out("R9 all off", 12'h000, F_NONE);
        prog_on = 12'h03C; step(1);
        expect_out("R9 no turn on", 12'h000, F_NONE);
        tsd_lvl[4] = 1'b0; step(1);
        expect_out("R9 restore", 12'h03C, F_NONE);

        // R1 sleep
        en_pin = 1'b0; tw_lvl[0] = 1'b1; step(1);
        expect_out("R1 sleep", 12'h000, F_NONE);
        en_pin = 1'b1; step(1);
        expect_out("R1 wake", 12'h03C, F_TW);
        tw_lvl[0] = 1'b0;

        @(negedge clk);
        #1;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule